// File: doc/BRIEF.md
# Postfix Evaluation Stack

This block is a small last-in first-out store built from registers, with two arithmetic commands that let it evaluate expressions already written in postfix order. A controller sends one command per cycle through a valid strobe and a two-bit operation code. The operation either places a word on the stack, takes the top word back out, or merges the two top entries into their sum or their product.

The stack grows toward address zero. The pointer sits one past the last slot while nothing is stored. It is decremented before a store and incremented after a read. Two sticky flags report the full and empty conditions. A command that cannot complete leaves every piece of state as it was and raises a one-cycle error pulse instead.

Top module: `stk_rpn_calc`

## Requirements
- R1: While reset is high and in the first cycle after it, `empty` is 1, `full` is 0, `err` is 0 and `rd_valid` is 0.
- R2: Operation codes are 0 = store, 1 = take, 2 = add, 3 = multiply. An accepted take asserts `rd_valid` for the one cycle after the command, and `rd_data` then holds the word most recently stored and not yet removed.
- R3: The stack holds `DEPTH` words (11 by default). The first accepted store clears `empty`. `full` rises after the store that fills the last free slot.
- R4: A take that removes the last stored word sets `empty`. Any accepted take or arithmetic command clears `full`. `full` and `empty` are never 1 together.
- R5: A store while `full` is 1 is rejected. `err` is 1 for exactly the next cycle, and the stack contents and flags are unchanged.
- R6: A take while `empty` is 1 is rejected. `err` pulses, `rd_valid` stays 0 and `empty` stays 1.
- R7: Add removes the top two words and stores their sum, truncated to `DATA_W` bits, as the new top. The entry count drops by one.
- R8: Multiply removes the top two words and stores the low `DATA_W` bits of their product.
- R9: Add or multiply with fewer than two stored words is rejected. `err` pulses and the stack is unchanged.
- R10: The sequence store 3, store 4, multiply, store 5, store 6, multiply, add leaves exactly one entry, equal to 42.
- R11: A cycle with `cmd_valid` low changes nothing and produces neither `err` nor `rd_valid`, whatever the other command inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | Operation code (0 store, 1 take, 2 add, 3 multiply) |
| cmd_data | input | DATA_W | Word to store |
| rd_valid | output | 1 | `rd_data` carries a taken word |
| rd_data | output | DATA_W | Word returned by the last accepted take |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| err | output | 1 | Previous command was rejected |

## Verification
The bench fills the stack to the last slot and then tries one more store. A design with an off-by-one limit would either drop a word or raise `full` one entry early. It drains the stack to zero and then takes once more. A faulty underflow guard would return a stale word with `rd_valid` set, or wrap the pointer. Arithmetic is tried at zero and one entries, where a weak entry-count check would merge garbage. Sums and products that exceed the word width are included, where a wrong truncation would show. Idle cycles with a live-looking opcode catch a design that decodes `cmd_op` without qualifying it by `cmd_valid`.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_ADD  = 2'd2,
    OP_MUL  = 2'd3
  } stk_op_e;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DEPTH = 11,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  stk_op_e       cmd_op,
  output logic          full,
  output logic          empty,
  output logic          err,
  output logic          wr_en,
  output logic [PW-1:0] wr_addr,
  output logic          pop_go,
  output logic [PW-1:0] top_addr,
  output logic [PW-1:0] nxt_addr
);
  localparam logic [PW-1:0] SP_EMPTY = PW'(DEPTH);
  localparam logic [PW-1:0] SP_TWO   = PW'(DEPTH - 2);

  logic [PW-1:0] sp_q, sp_d;
  logic push_req, pop_req, bin_req;
  logic push_ok, pop_ok, bin_ok, reject;

  always_comb begin
    push_req = cmd_valid && (cmd_op == OP_PUSH);
    pop_req  = cmd_valid && (cmd_op == OP_POP);
    bin_req  = cmd_valid && ((cmd_op == OP_ADD) || (cmd_op == OP_MUL));
    push_ok  = push_req && !full;
    pop_ok   = pop_req && !empty;
    bin_ok   = bin_req && (sp_q <= SP_TWO);
    reject   = cmd_valid && !(push_ok || pop_ok || bin_ok);
    if (push_ok)               sp_d = sp_q - 1'b1;
    else if (pop_ok || bin_ok) sp_d = sp_q + 1'b1;
    else                       sp_d = sp_q;
  end

  assign wr_en    = push_ok || bin_ok;
  assign wr_addr  = push_ok ? (sp_q - 1'b1) : (sp_q + 1'b1);
  assign pop_go   = pop_ok;
  assign top_addr = sp_q;
  assign nxt_addr = sp_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= SP_EMPTY;
      full  <= 1'b0;
      empty <= 1'b1;
      err   <= 1'b0;
    end else begin
      sp_q <= sp_d;
      err  <= reject;
      if (push_ok) begin
        full  <= (sp_d == '0);
        empty <= 1'b0;
      end else if (pop_ok) begin
        full  <= 1'b0;
        empty <= (sp_d == SP_EMPTY);
      end else if (bin_ok) begin
        full  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int DEPTH  = 11,
  parameter int DATA_W = 16,
  parameter int PW     = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PW-1:0]     rd_addr_a,
  input  logic [PW-1:0]     rd_addr_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam logic [PW-1:0] LIMIT = PW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < LIMIT)) mem[wr_addr] <= wr_data;
  end

  assign rd_data_a = (rd_addr_a < LIMIT) ? mem[rd_addr_a] : '0;
  assign rd_data_b = (rd_addr_b < LIMIT) ? mem[rd_addr_b] : '0;
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  stk_op_e           op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(opa) * PROD_W'(opb);
    if (op == OP_MUL) res = prod[DATA_W-1:0];
    else              res = opa + opb;
  end
endmodule

// File: rtl/stk_rpn_calc.sv
module stk_rpn_calc
  import stk_pkg::*;
#(
  parameter int DEPTH  = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              err
);
  localparam int PW = $clog2(DEPTH + 2);

  stk_op_e           op_e;
  logic              wr_en, pop_go;
  logic [PW-1:0]     wr_addr, top_addr, nxt_addr;
  logic [DATA_W-1:0] top_word, nxt_word, alu_res, wr_data;

  assign op_e = stk_op_e'(cmd_op);

  stk_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(op_e),
    .full(full), .empty(empty), .err(err),
    .wr_en(wr_en), .wr_addr(wr_addr), .pop_go(pop_go),
    .top_addr(top_addr), .nxt_addr(nxt_addr)
  );

  stk_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PW(PW)) u_rf (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(top_addr), .rd_addr_b(nxt_addr),
    .rd_data_a(top_word), .rd_data_b(nxt_word)
  );

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op_e), .opa(top_word), .opb(nxt_word), .res(alu_res)
  );

  assign wr_data = (op_e == OP_PUSH) ? cmd_data : alu_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pop_go;
      if (pop_go) rd_data <= top_word;
    end
  end
endmodule

// File: rtl/stk_rpn_calc_chk.sv
module stk_rpn_calc_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       rd_valid,
  input logic       full,
  input logic       empty,
  input logic       err
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_q) reset_state_chk: assert (empty && !full && !err && !rd_valid);
  end

  // R2
  pop_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1 && !empty) |=> (rd_valid && !err));

  // R3
  push_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0 && !full) |=> (!empty && !err));

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0 && full) |=> (err && full));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1 && empty) |=> (err && !rd_valid && empty));

  // R9
  bin_empty_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op[1] && empty) |=> (err && empty));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (!err && !rd_valid && $stable(full) && $stable(empty)));
endmodule

bind stk_rpn_calc stk_rpn_calc_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rd_valid(rd_valid), .full(full), .empty(empty), .err(err)
);

// File: tb/stk_rpn_calc_tb_top.sv
`timescale 1ns/1ps
module stk_rpn_calc_tb_top;
  localparam int DEPTH = 11;
  localparam int DW    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [DW-1:0] cmd_data = '0;
  logic          rd_valid, full, empty, err;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] mdl [$];

  always #5 clk = ~clk;

  stk_rpn_calc #(.DEPTH(DEPTH), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .full(full), .empty(empty), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] calc(input logic [1:0] op,
                                          input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    logic [2*DW-1:0] p;
    p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    return (op == 2'd3) ? p[DW-1:0] : DW'(a + b);
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [DW-1:0] d,
                         input string req);
    bit e_err, e_rv;
    logic [DW-1:0] e_rd, a, b;
    int n;
    e_err = 1'b0; e_rv = 1'b0; e_rd = '0;
    n = mdl.size();
    case (op)
      2'd0: if (n >= DEPTH) e_err = 1'b1; else mdl.push_back(d);
      2'd1: if (n == 0) e_err = 1'b1;
            else begin e_rv = 1'b1; e_rd = mdl.pop_back(); end
      default: if (n < 2) e_err = 1'b1;
               else begin
                 a = mdl.pop_back(); b = mdl.pop_back();
                 mdl.push_back(calc(op, a, b));
               end
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    chk(err == e_err, req, "err", 32'(err), 32'(e_err));
    chk(rd_valid == e_rv, req, "rd_valid", 32'(rd_valid), 32'(e_rv));
    if (e_rv) chk(rd_data == e_rd, req, "rd_data", 32'(rd_data), 32'(e_rd));
    chk(full == (mdl.size() == DEPTH), req, "full", 32'(full),
        32'(mdl.size() == DEPTH));
    chk(empty == (mdl.size() == 0), req, "empty", 32'(empty),
        32'(mdl.size() == 0));
  endtask

  task automatic idle(input logic [1:0] junk, input string req);
    logic f0, e0;
    @(negedge clk);
    f0 = full; e0 = empty;
    cmd_valid = 1'b0; cmd_op = junk; cmd_data = DW'($urandom);
    @(posedge clk); #1;
    chk(!err && !rd_valid, req, "idle strobes", {30'd0, err, rd_valid}, 32'd0);
    chk(full == f0 && empty == e0, req, "idle flags", {30'd0, full, empty},
        {30'd0, f0, e0});
  endtask

  task automatic drain(input string req);
    while (mdl.size() > 0) run_cmd(2'd1, '0, req);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    // R1: state while in reset
    chk(empty && !full && !err && !rd_valid, "R1", "reset state",
        {28'd0, empty, full, err, rd_valid}, 32'h8);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(empty && !full && !err && !rd_valid, "R1", "after reset",
        {28'd0, empty, full, err, rd_valid}, 32'h8);

    // R10: postfix example
    run_cmd(2'd0, 16'd3, "R10"); run_cmd(2'd0, 16'd4, "R10");
    run_cmd(2'd3, '0, "R10");
    run_cmd(2'd0, 16'd5, "R10"); run_cmd(2'd0, 16'd6, "R10");
    run_cmd(2'd3, '0, "R10"); run_cmd(2'd2, '0, "R10");
    chk(mdl.size() == 1 && mdl[0] == 16'd42, "R10", "model", 32'(mdl[0]), 32'd42);
    run_cmd(2'd1, '0, "R10");

    // R9: arithmetic with zero and one entry
    run_cmd(2'd2, '0, "R9"); run_cmd(2'd3, '0, "R9");
    run_cmd(2'd0, 16'h0077, "R9"); run_cmd(2'd2, '0, "R9");
    run_cmd(2'd3, '0, "R9"); run_cmd(2'd1, '0, "R9");

    // R6: take while empty
    run_cmd(2'd1, '0, "R6"); run_cmd(2'd1, '0, "R6");

    // R3 / R5: fill, then overflow
    for (int i = 0; i < DEPTH; i++) run_cmd(2'd0, DW'(16'h100 + i), "R3");
    run_cmd(2'd0, 16'hDEAD, "R5"); run_cmd(2'd0, 16'hBEEF, "R5");
    // R11: idle while full with an opcode that would take
    idle(2'd1, "R11");
    // R2 / R4: drain in LIFO order
    drain("R4");
    idle(2'd0, "R11");

    // R7: wrap of the sum
    run_cmd(2'd0, 16'hFFFF, "R7"); run_cmd(2'd0, 16'h0002, "R7");
    run_cmd(2'd2, '0, "R7"); run_cmd(2'd1, '0, "R7");
    // R8: low word of the product
    run_cmd(2'd0, 16'h0100, "R8"); run_cmd(2'd0, 16'h0100, "R8");
    run_cmd(2'd3, '0, "R8");
    run_cmd(2'd0, 16'h1234, "R8"); run_cmd(2'd3, '0, "R8");
    run_cmd(2'd0, 16'h1234, "R8"); run_cmd(2'd0, 16'h0003, "R8");
    run_cmd(2'd3, '0, "R8");
    drain("R8");

    // R2: random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4)       run_cmd(2'd0, DW'($urandom), "R2");
      else if (r < 7)  run_cmd(2'd1, '0, "R2");
      else if (r == 7) run_cmd(2'd2, '0, "R7");
      else if (r == 8) run_cmd(2'd3, '0, "R8");
      else             idle(2'($urandom), "R11");
    end
    drain("R2");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule